// File: doc/BRIEF.md
# Frame Acceptance Gate with External Reject Window

This block makes the final keep-or-discard call for each received frame. It combines three kinds of input:

- the internal address match results, which come from a matcher outside this block;
- the configuration bits, including promiscuous mode, the per-class receive disables and duplex settings;
- an active-low reject input driven by external address lookup logic.

The reject input only counts while the frame is inside a fixed bit-time window that opens shortly after the start-of-frame delimiter. A reject seen in that window is remembered until the next delimiter.

Upstream receive logic provides the following:

- a one-cycle pulse when the delimiter is found;
- a bit count since that delimiter;
- a receive-active level that stays high for the whole frame.

When receive-active falls, the block issues a single-cycle keep or discard pulse. Certain conditions override any external reject: promiscuous mode, a physical address hit, a logical filter hit and an enabled broadcast frame. When every internal match path is switched off, external detection alone decides, so a frame is kept unless it was rejected. In full-duplex operation the reject input is honoured only if a separate enable is set.

Top module: `frame_accept_gate`

## Requirements
- R1: While reset is high and after it is released, both `frame_keep` and `frame_drop` are 0 until a frame ends.
- R2: When external rejects are honoured, `reject_n` = 0 sampled while `rx_active` = 1 and `bit_cnt` is between 2 and 512 inclusive marks the frame as rejected. A single such sample at `bit_cnt` 2 or at 512 is enough.
- R3: `reject_n` = 0 at `bit_cnt` 0, 1, or 513 and above has no effect on the verdict.
- R4: The rejected mark persists after `reject_n` returns high, until the end of the frame. It is cleared by the next `sfd_seen` pulse, so the following frame starts unrejected.
- R5: Each of these causes the frame to be kept whatever `reject_n` did: `phys_hit` with `phys_rx_dis` = 0, `lfilt_hit`, or `bcast_frame` with `bcast_rx_dis` = 0.
- R6: With `promisc` = 1, every frame is kept and `reject_n` is ignored.
- R7: With `ext_en` = 1 and internal matching disabled, every frame is kept unless it was rejected in the window. Internal matching is disabled when `promisc` = 0, `phys_rx_dis` = 1, `bcast_rx_dis` = 1 and `lfilt_bits` is all zero.
- R8: With `ext_en` = 1, internal matching enabled and no internal hit, the frame is discarded.
- R9: With `full_duplex` = 1, `reject_n` is ignored unless `fd_rej_en` = 1.
- R10: With `ext_en` = 0, `reject_n` has no effect. A frame is kept only on an internal hit or promiscuous mode.
- R11: The verdict is a one-cycle pulse on exactly one of `frame_keep` or `frame_drop`. It appears in the cycle after the clock edge that first samples `rx_active` low following a high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_active | input | 1 | High for the duration of a received frame |
| sfd_seen | input | 1 | One-cycle pulse when the start-of-frame delimiter is found |
| bit_cnt | input | CNT_W | Bit times elapsed since the delimiter |
| reject_n | input | 1 | External reject, active low |
| phys_hit | input | 1 | Internal physical address match |
| lfilt_hit | input | 1 | Internal logical filter hit |
| bcast_frame | input | 1 | Frame carries the broadcast destination |
| lfilt_bits | input | LAF_W | Logical filter contents |
| ext_en | input | 1 | External address detection enabled |
| promisc | input | 1 | Promiscuous mode |
| phys_rx_dis | input | 1 | Physical address reception disabled |
| bcast_rx_dis | input | 1 | Broadcast reception disabled |
| full_duplex | input | 1 | Link is in full-duplex mode |
| fd_rej_en | input | 1 | Honour the reject input in full-duplex mode |
| frame_keep | output | 1 | One-cycle pulse: frame accepted |
| frame_drop | output | 1 | One-cycle pulse: frame discarded |

## Verification
Inputs change on the falling clock edge. The bench samples `reject_n` at the rising edge, so a reject affects the stored mark one edge later. The verdict registers update at the first rising edge that sees `rx_active` low, and the pulse is therefore read at the next falling edge, then read again one cycle later to confirm it has cleared. A behavioural model that applies the same edge timing is compared with both outputs at every falling edge. The reject samples are placed at bit counts 1, 2, 512 and 513 to probe the window boundaries exactly.

// File: rtl/fag_pkg.sv
package fag_pkg;

  typedef struct packed {
    logic ext_en;
    logic promisc;
    logic phys_rx_dis;
    logic bcast_rx_dis;
    logic full_duplex;
    logic fd_rej_en;
  } fag_cfg_t;

  typedef enum logic [1:0] {
    WHY_NONE    = 2'd0,
    WHY_PROMISC = 2'd1,
    WHY_HIT     = 2'd2,
    WHY_EXT     = 2'd3
  } fag_reason_t;

endpackage

// File: rtl/fag_window.sv
module fag_window #(
  parameter int CNT_W  = 16,
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sfd_seen,
  input  logic             rx_active,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             reject_n,
  input  logic             honour,
  output logic             rej_flag
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] HI = CNT_W'(WIN_HI);

  logic in_win;
  assign in_win = (bit_cnt >= LO) && (bit_cnt <= HI);

  always_ff @(posedge clk) begin
    if (rst)
      rej_flag <= 1'b0;
    else if (sfd_seen)
      rej_flag <= 1'b0;
    else if (rx_active && honour && in_win && !reject_n)
      rej_flag <= 1'b1;
  end

  AST_SFD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sfd_seen |=> !rej_flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rej_flag && !sfd_seen) |=> rej_flag); // R4
  AST_SET_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(rej_flag) |-> $past(!reject_n && bit_cnt >= LO && bit_cnt <= HI)); // R3

endmodule

// File: rtl/fag_policy.sv
module fag_policy #(
  parameter int LAF_W = 64
) (
  input  fag_pkg::fag_cfg_t  cfg,
  input  logic               phys_hit,
  input  logic               lfilt_hit,
  input  logic               bcast_frame,
  input  logic [LAF_W-1:0]   lfilt_bits,
  input  logic               rej_flag,
  output logic               honour,
  output logic               verdict_keep,
  output fag_pkg::fag_reason_t reason
);
  import fag_pkg::*;

  logic internal_hit;
  logic internal_off;

  assign honour       = cfg.ext_en && (!cfg.full_duplex || cfg.fd_rej_en);
  assign internal_hit = (phys_hit && !cfg.phys_rx_dis) || lfilt_hit ||
                        (bcast_frame && !cfg.bcast_rx_dis);
  assign internal_off = !cfg.promisc && cfg.phys_rx_dis && cfg.bcast_rx_dis &&
                        (lfilt_bits == '0);

  always_comb begin
    verdict_keep = 1'b0;
    reason       = WHY_NONE;
    if (cfg.promisc) begin
      verdict_keep = 1'b1;
      reason       = WHY_PROMISC;
    end else if (internal_hit) begin
      verdict_keep = 1'b1;
      reason       = WHY_HIT;
    end else if (cfg.ext_en && internal_off) begin
      verdict_keep = !rej_flag;
      reason       = WHY_EXT;
    end
  end

endmodule

// File: rtl/fag_edge.sv
module fag_edge (
  input  logic clk,
  input  logic rst,
  input  logic rx_active,
  input  logic verdict_keep,
  output logic frame_keep,
  output logic frame_drop
);
  logic rx_q;
  logic fall;

  assign fall = rx_q && !rx_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q       <= 1'b0;
      frame_keep <= 1'b0;
      frame_drop <= 1'b0;
    end else begin
      rx_q       <= rx_active;
      frame_keep <= fall && verdict_keep;
      frame_drop <= fall && !verdict_keep;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !(frame_keep && frame_drop)); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (frame_keep || frame_drop) |=> !(frame_keep || frame_drop)); // R11
  AST_AT_END_ONLY: assert property (@(posedge clk) disable iff (rst)
    (frame_keep || frame_drop) |-> !$past(rx_active)); // R11

endmodule

// File: rtl/frame_accept_gate.sv
module frame_accept_gate #(
  parameter int CNT_W  = 16,
  parameter int LAF_W  = 64,
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_active,
  input  logic             sfd_seen,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             reject_n,
  input  logic             phys_hit,
  input  logic             lfilt_hit,
  input  logic             bcast_frame,
  input  logic [LAF_W-1:0] lfilt_bits,
  input  logic             ext_en,
  input  logic             promisc,
  input  logic             phys_rx_dis,
  input  logic             bcast_rx_dis,
  input  logic             full_duplex,
  input  logic             fd_rej_en,
  output logic             frame_keep,
  output logic             frame_drop
);
  import fag_pkg::*;

  fag_cfg_t    cfg;
  logic        honour;
  logic        rej_flag;
  logic        verdict_keep;
  fag_reason_t reason;

  assign cfg = '{ext_en: ext_en, promisc: promisc, phys_rx_dis: phys_rx_dis,
                 bcast_rx_dis: bcast_rx_dis, full_duplex: full_duplex,
                 fd_rej_en: fd_rej_en};

  fag_window #(.CNT_W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_window (
    .clk(clk), .rst(rst), .sfd_seen(sfd_seen), .rx_active(rx_active),
    .bit_cnt(bit_cnt), .reject_n(reject_n), .honour(honour),
    .rej_flag(rej_flag)
  );

  fag_policy #(.LAF_W(LAF_W)) u_policy (
    .cfg(cfg), .phys_hit(phys_hit), .lfilt_hit(lfilt_hit),
    .bcast_frame(bcast_frame), .lfilt_bits(lfilt_bits), .rej_flag(rej_flag),
    .honour(honour), .verdict_keep(verdict_keep), .reason(reason)
  );

  fag_edge u_edge (
    .clk(clk), .rst(rst), .rx_active(rx_active), .verdict_keep(verdict_keep),
    .frame_keep(frame_keep), .frame_drop(frame_drop)
  );

  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_active) && !$past(rst) && promisc) |=> frame_keep); // R6
  AST_PHYS_HIT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_active) && !$past(rst) && phys_hit && !phys_rx_dis) |=> frame_keep); // R5
  AST_REASON_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (reason == WHY_NONE) |-> !verdict_keep); // R8

endmodule

// File: tb/frame_accept_gate_tb.sv
module frame_accept_gate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_active = 1'b0, sfd_seen = 1'b0, reject_n = 1'b1;
  logic [15:0] bit_cnt = '0;
  logic        phys_hit = 0, lfilt_hit = 0, bcast_frame = 0;
  logic [63:0] lfilt_bits = '0;
  logic        ext_en = 0, promisc = 0, phys_rx_dis = 0, bcast_rx_dis = 0;
  logic        full_duplex = 0, fd_rej_en = 0;
  logic        frame_keep, frame_drop;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frame_accept_gate u_dut (
    .clk(clk), .rst(rst), .rx_active(rx_active), .sfd_seen(sfd_seen),
    .bit_cnt(bit_cnt), .reject_n(reject_n), .phys_hit(phys_hit),
    .lfilt_hit(lfilt_hit), .bcast_frame(bcast_frame), .lfilt_bits(lfilt_bits),
    .ext_en(ext_en), .promisc(promisc), .phys_rx_dis(phys_rx_dis),
    .bcast_rx_dis(bcast_rx_dis), .full_duplex(full_duplex),
    .fd_rej_en(fd_rej_en), .frame_keep(frame_keep), .frame_drop(frame_drop)
  );

  // Behavioural reference model
  bit m_flag, m_rx, mk, md;
  always @(posedge clk) begin
    bit hon, hit, off, acc;
    if (rst) begin
      m_flag = 0; m_rx = 0; mk = 0; md = 0;
    end else begin
      mk = 0; md = 0;
      if (m_rx && !rx_active) begin
        hit = (phys_hit && !phys_rx_dis) || lfilt_hit || (bcast_frame && !bcast_rx_dis);
        off = !promisc && phys_rx_dis && bcast_rx_dis && (lfilt_bits == 0);
        if (promisc) acc = 1;
        else if (hit) acc = 1;
        else if (ext_en && off) acc = !m_flag;
        else acc = 0;
        mk = acc; md = !acc;
      end
      hon = ext_en && (!full_duplex || fd_rej_en);
      if (sfd_seen) m_flag = 0;
      else if (rx_active && hon && !reject_n && int'(bit_cnt) >= 2 && int'(bit_cnt) <= 512)
        m_flag = 1;
      m_rx = rx_active;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(frame_keep, mk, "R11 model keep");
      chk(frame_drop, md, "R11 model drop");
    end
  end

  task automatic run_frame(input int lo, input int hi, input bit exp, input string req);
    @(negedge clk);
    sfd_seen = 1; rx_active = 1; bit_cnt = 0;
    reject_n = !(0 >= lo && 0 <= hi);
    for (int b = 1; b <= 600; b++) begin
      @(negedge clk);
      sfd_seen = 0; bit_cnt = 16'(b);
      reject_n = !(b >= lo && b <= hi);
    end
    @(negedge clk);
    rx_active = 0; reject_n = 1; bit_cnt = 0;
    @(negedge clk);
    chk(frame_keep, exp, req);
    chk(frame_drop, !exp, req);
    @(negedge clk);
    chk(frame_keep || frame_drop, 1'b0, "R11 pulse cleared");
  endtask

  task automatic cfg_ext_only();
    ext_en = 1; promisc = 0; phys_rx_dis = 1; bcast_rx_dis = 1; lfilt_bits = '0;
    phys_hit = 0; lfilt_hit = 0; bcast_frame = 0; full_duplex = 0; fd_rej_en = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frame_keep, 1'b0, "R1 reset keep");
    chk(frame_drop, 1'b0, "R1 reset drop");
    rst = 0;
    repeat (2) @(negedge clk);
    chk(frame_keep || frame_drop, 1'b0, "R1 after reset");

    cfg_ext_only();
    run_frame(-1, -1, 1, "R7 no reject kept");
    run_frame(2, 2, 0, "R2 reject at 2");
    run_frame(512, 512, 0, "R2 reject at 512");
    run_frame(1, 1, 1, "R3 reject at 1 ignored");
    run_frame(513, 540, 1, "R3 reject after 512 ignored");
    run_frame(100, 110, 0, "R4 sticky after release");
    run_frame(-1, -1, 1, "R4 cleared by next delimiter");

    phys_rx_dis = 0; phys_hit = 1;
    run_frame(50, 60, 1, "R5 physical hit overrides");
    phys_hit = 0; bcast_rx_dis = 0; bcast_frame = 1;
    run_frame(50, 60, 1, "R5 broadcast overrides");
    bcast_frame = 0; lfilt_bits = 64'h10; lfilt_hit = 1;
    run_frame(50, 60, 1, "R5 logical hit overrides");
    lfilt_hit = 0;
    run_frame(-1, -1, 0, "R8 enabled matcher no hit");

    cfg_ext_only(); promisc = 1;
    run_frame(10, 500, 1, "R6 promiscuous keeps");

    cfg_ext_only(); full_duplex = 1;
    run_frame(10, 20, 1, "R9 duplex reject ignored");
    fd_rej_en = 1;
    run_frame(10, 20, 0, "R9 duplex reject honoured");

    cfg_ext_only(); ext_en = 0;
    run_frame(-1, -1, 0, "R10 no detection no hit");
    phys_rx_dis = 0; phys_hit = 1;
    run_frame(10, 20, 1, "R10 reject no effect");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule